// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block produces a periodic tick interrupt for a real-time-clock peripheral. A strobe input marks each period of a 32768 Hz time base. A prescaler divides that strobe rate by a power of two picked by a 4-bit select field. A down-counter counts the divided ticks. Each time it expires it raises a pending flag, reloads itself from a programmable reload register and keeps running. The pending flag drives a level interrupt. Software clears the flag by writing a one to it.

Software reaches the block through a small word-wide register port with four locations: status, control, reload and live count. A write takes effect on the clock edge where the write strobe is high. Read data is registered and appears one cycle after the address is presented.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset, the status, control, reload and count locations all read 0 and `irq_tick` is low.
- R2: A write to the reload location (address 2) is stored only when the written value is greater than 2. A write of 0, 1 or 2 leaves the previous reload value in place.
- R3: The counter starts only when the tick-run bit (control bit 8) goes from 0 to 1 in a control write (address 1) that also sets the master-enable bit (control bit 0), and only if the reload value is nonzero. Starting loads the count with the reload value. A control write where bit 8 was already 1 does not reload the count.
- R4: While running, each divided tick lowers the count by one. The divided tick that finds the count at 1 sets the pending flag and reloads the count from the reload value, so the flag sets once every N divided ticks for a reload value N, and counting goes on.
- R5: One divided tick occurs for every 2^S time-base strobes, where S is the active select value. The prescaler restarts when the counter starts, so the first divided tick comes on the 2^S-th strobe after the start.
- R6: The active select value is taken from control bits [7:4] only by a control write that sets bit 0. Reading the control location returns the last written control word with bits [7:4] replaced by the active select value.
- R7: A control write that clears bit 8 stops the counter. A control write that clears bit 0 stops it whatever the state of bit 8. A stopped count holds its value.
- R8: Writing a word to the status location (address 0) with bit 0 set clears the pending flag. Writing bit 0 as 0 leaves the flag unchanged.
- R9: `irq_tick` is high exactly while the pending flag is set. The flag reads back as status bit 0.
- R10: Reading address 3 returns the live count value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | One-cycle strobe at each 32768 Hz time-base period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 control, 2 reload, 3 count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_tick | output | 1 | Level tick interrupt |

## Verification
The counter is run at select value 0, where each strobe is one tick, and at select value 2, where the 11th and 12th strobes after a start show whether the prescaler restarts and whether the division is right. The count is read back after partial runs, after a repeated control write with bit 8 already set, and after stops through each enable bit. This separates a missing reload or a wrong edge detection from a counter that never froze. Reload values of 1 and 2 and a start with a zero reload check the rejection and start guards. Status writes of 0 and of 1 check that only a one clears the flag.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  typedef enum logic [1:0] {
    ADR_STATUS = 2'd0,
    ADR_CTRL   = 2'd1,
    ADR_RELOAD = 2'd2,
    ADR_COUNT  = 2'd3
  } reg_addr_e;

  localparam int MASTER_EN_BIT = 0;
  localparam int RUN_BIT       = 8;
  localparam int SEL_LSB       = 4;
  localparam int MIN_RELOAD    = 2;
endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
  parameter int PRE_W = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             ref_pulse,
  input  logic [SEL_W-1:0] sel,
  output logic             div_tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      low_mask[i] = (i < int'(sel));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
    end else if (ref_pulse) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign div_tick = ref_pulse && !restart && ((pre_q & low_mask) == low_mask);
endmodule

// File: rtl/rtc_tick_regs.sv
module rtc_tick_regs
  import rtc_tick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              expire,
  output logic              start,
  output logic              stop,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  reload,
  output logic [DATA_W-1:0] ctrl_view,
  output logic              pending
);
  localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

  logic [DATA_W-1:0] ctrl_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  reload_q;
  logic              pend_q;
  logic              wr_ctrl, wr_reload, wr_status;
  logic              new_en, new_run;

  assign wr_ctrl   = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_reload = reg_wr && (reg_addr == ADR_RELOAD);
  assign wr_status = reg_wr && (reg_addr == ADR_STATUS);
  assign new_en    = reg_wdata[MASTER_EN_BIT];
  assign new_run   = reg_wdata[RUN_BIT];

  assign start = wr_ctrl && new_en && new_run && !ctrl_q[RUN_BIT] && (reload_q != '0);
  assign stop  = wr_ctrl && (!new_en || !new_run);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      sel_q    <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= reg_wdata;
        if (new_en) begin
          sel_q <= reg_wdata[SEL_MSB:SEL_LSB];
        end
      end
      if (wr_reload && (reg_wdata > DATA_W'(MIN_RELOAD))) begin
        reload_q <= reg_wdata[CNT_W-1:0];
      end
      if (expire) begin
        pend_q <= 1'b1;
      end else if (wr_status && reg_wdata[0]) begin
        pend_q <= 1'b0;
      end
    end
  end

  generate
    if (DATA_W > SEL_MSB + 1) begin : g_view_hi
      assign ctrl_view = {ctrl_q[DATA_W-1:SEL_MSB+1], sel_q, ctrl_q[SEL_LSB-1:0]};
    end else begin : g_view_lo
      assign ctrl_view = {sel_q, ctrl_q[SEL_LSB-1:0]};
    end
  endgenerate

  assign sel     = sel_q;
  assign reload  = reload_q;
  assign pending = pend_q;
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             div_tick,
  input  logic [CNT_W-1:0] reload,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == CNT_W'(1));
  assign expire  = run_q && div_tick && at_last && !start && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= reload;
    end else if (run_q && div_tick) begin
      cnt_q <= at_last ? reload : cnt_q - 1'b1;
    end
  end

  assign running = run_q;
  assign count   = cnt_q;
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_tick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 15,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_pulse,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_tick
);
  logic              start, stop, expire, div_tick, run_q, pending;
  logic [SEL_W-1:0]  sel;
  logic [CNT_W-1:0]  reload_q, cnt_q;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] rdata_q;

  rtc_tick_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .expire(expire), .start(start), .stop(stop),
    .sel(sel), .reload(reload_q), .ctrl_view(ctrl_view), .pending(pending)
  );

  rtc_tick_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .restart(start), .ref_pulse(ref_pulse),
    .sel(sel), .div_tick(div_tick)
  );

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .div_tick(div_tick),
    .reload(reload_q), .running(run_q), .count(cnt_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (reg_addr)
        ADR_STATUS: rdata_q <= DATA_W'(pending);
        ADR_CTRL:   rdata_q <= ctrl_view;
        ADR_RELOAD: rdata_q <= DATA_W'(reload_q);
        default:    rdata_q <= DATA_W'(cnt_q);
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_tick  = pending;
endmodule

// File: rtl/rtc_tick_checker.sv
module rtc_tick_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq_tick,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              div_tick,
  input logic [CNT_W-1:0]  reload_q
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 2'd1);

  p_expire_sets_irq_r4: assert property (@(posedge clk) disable iff (rst)
    (run_q && div_tick && cnt_q == CNT_W'(1) && !ctrl_wr) |=> irq_tick);

  p_running_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));

  p_irq_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_tick && !(reg_wr && reg_addr == 2'd0 && reg_wdata[0])) |=> irq_tick);

  p_small_reload_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2 && reg_wdata <= DATA_W'(2)) |=> $stable(reload_q));

  p_stopped_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ctrl_wr) |=> $stable(cnt_q));
endmodule

bind rtc_tick_timer rtc_tick_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_tick(irq_tick), .run_q(run_q),
  .cnt_q(cnt_q), .div_tick(div_tick), .reload_q(reload_q)
);

// File: tb/rtc_tick_timer_bench.sv
module rtc_tick_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_pulse = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rtc_tick_timer u_rtc_tick_timer (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_tick(irq_tick)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_pulse = 1'b1;
      @(negedge clk) ref_pulse = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq_tick}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reg", v, 32'd0);
    end
  endtask

  task automatic t_zero_reload_start();
    logic [31:0] v;
    wr(2'd1, 32'h101);
    pulses(3);
    rd(2'd3, v);
    check("R3 zero reload no start", v, 32'd0);
    check("R3 irq idle", {31'b0, irq_tick}, 32'd0);
    wr(2'd1, 32'h000);
  endtask

  task automatic t_reload_guard();
    logic [31:0] v;
    wr(2'd2, 32'd2);
    rd(2'd2, v);
    check("R2 reject 2", v, 32'd0);
    wr(2'd2, 32'd5);
    rd(2'd2, v);
    check("R2 accept 5", v, 32'd5);
    wr(2'd2, 32'd1);
    rd(2'd2, v);
    check("R2 reject 1", v, 32'd5);
  endtask

  task automatic t_count_sel0();
    logic [31:0] v;
    wr(2'd1, 32'h101);
    rd(2'd3, v);
    check("R10 live count after start", v, 32'd5);
    pulses(2);
    rd(2'd3, v);
    check("R4 count after 2", v, 32'd3);
    wr(2'd1, 32'h101);
    rd(2'd3, v);
    check("R3 no restart when bit8 already set", v, 32'd3);
    pulses(2);
    check("R4 no irq before expiry", {31'b0, irq_tick}, 32'd0);
    pulses(1);
    check("R4 irq on expiry", {31'b0, irq_tick}, 32'd1);
    rd(2'd3, v);
    check("R4 reloaded", v, 32'd5);
    rd(2'd0, v);
    check("R9 status bit0 follows irq", v, 32'd1);
  endtask

  task automatic t_status_clear();
    wr(2'd0, 32'h0);
    check("R8 write 0 keeps flag", {31'b0, irq_tick}, 32'd1);
    wr(2'd0, 32'h1);
    check("R8 write 1 clears flag", {31'b0, irq_tick}, 32'd0);
    pulses(5);
    check("R4 keeps running", {31'b0, irq_tick}, 32'd1);
    wr(2'd0, 32'h1);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    pulses(2);
    wr(2'd1, 32'h001);
    pulses(3);
    rd(2'd3, v);
    check("R7 bit8 clear freezes", v, 32'd3);
    wr(2'd1, 32'h101);
    pulses(1);
    wr(2'd1, 32'h100);
    pulses(2);
    rd(2'd3, v);
    check("R7 bit0 clear freezes", v, 32'd4);
    check("R7 no irq while stopped", {31'b0, irq_tick}, 32'd0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(2'd1, 32'h000);
    wr(2'd1, 32'h021);
    rd(2'd1, v);
    check("R6 select taken with bit0", v, 32'h021);
    wr(2'd1, 32'h070);
    rd(2'd1, v);
    check("R6 select kept without bit0", v, 32'h020);
    wr(2'd2, 32'd3);
    wr(2'd1, 32'h121);
    pulses(11);
    check("R5 no irq after 11 strobes", {31'b0, irq_tick}, 32'd0);
    rd(2'd3, v);
    check("R5 count after 11 strobes", v, 32'd1);
    pulses(1);
    check("R5 irq after 12 strobes", {31'b0, irq_tick}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_reload_start();
    t_reload_guard();
    t_count_sel0();
    t_status_clear();
    t_stop();
    t_prescale();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule